// File: doc/BRIEF.md
# UART Receive Queue with Status Flags

This block sits on the receive side of a memory-mapped UART, between the serial deserializer and the register interface. Each received character is pushed into a 16-entry queue. A character can carry a break, framing-error or parity-error indication. The block keeps five sticky flags: ready, overrun, break, framing error and parity error. It also exposes a status word that packs those flags together with the current fill level of the queue.

Software drives the block through a single command word. The command word has a separate set bit and a separate clear bit for every flag. A pull bit moves the oldest character into the data output, and a flush bit empties the queue. A character must be pulled before it is read.

The ready flag is not raised at once. It waits a programmable number of bit periods after the first character lands in an empty queue, so that a burst can collect before software is alerted. A full queue raises ready at once. The interrupt request is the OR of each flag masked by its enable.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the status word is zero, the fill level is zero and `irq` is low.
- R2: Characters accepted from `rx_valid` are kept in arrival order. A pull (`cmd_word` bit 10) places the oldest one on `rd_char` one clock after the command. The fill level appears in `status_word[10:6]`.
- R3: A character that arrives while 16 characters are held is dropped, and the overrun flag (`status_word[2]`) is set. If a pull lands in the same clock, the pull frees a slot: the character is accepted and overrun stays clear.
- R4: An arriving character that carries the break indication sets `status_word[3]`. The framing-error indication sets `status_word[4]`. The parity-error indication sets `status_word[5]`.
- R5: `cmd_word` bits 0..4 clear, and bits 5..9 set, the flags ready, overrun, break, framing and parity, in that order. When a set bit and a clear bit for the same flag are given together, the flag ends up set.
- R6: When a hardware event and a clear command hit the same flag in the same clock, the flag ends up set.
- R7: Ready (`status_word[0]`) is set after `cfg_ready_delay` pulses of `bit_tick` have been counted since a character entered an empty queue. A delay of zero sets ready one clock after that character enters.
- R8: Ready is set one clock after the fill level reaches 16, whatever the delay setting.
- R9: A flush (`cmd_word` bit 11) empties the queue. A character arriving in the same clock as a flush is discarded and does not set overrun. A pull on an empty queue leaves `rd_char` and the fill level unchanged.
- R10: `irq` is the registered OR of each flag ANDed with its enable in `cfg_irq_en`. The enable bits 0..4 follow the flag order of R5. `irq` lags the flags by one clock.
- R11: `status_word[1]` always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-clock strobe: a character is available from the deserializer |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Break indication qualified by `rx_valid` |
| rx_ferr | input | 1 | Framing-error indication qualified by `rx_valid` |
| rx_perr | input | 1 | Parity-error indication qualified by `rx_valid` |
| bit_tick | input | 1 | One-clock pulse per serial bit period |
| cmd_we | input | 1 | Command word strobe |
| cmd_word | input | 12 | Flag clear (0..4), flag set (5..9), pull (10), flush (11) |
| cfg_ready_delay | input | 8 | Ready delay, in bit periods |
| cfg_irq_en | input | 5 | Per-flag interrupt enables |
| rd_char | output | 8 | Most recently pulled character |
| status_word | output | 11 | Fill level [10:6], parity [5], framing [4], break [3], overrun [2], zero [1], ready [0] |
| irq | output | 1 | Receive interrupt request |

## Verification
Several functions of this block can fall in the same clock. Four such pairs are exercised:
- **Pull and arrival on a full queue.** An arrival is driven in the same clock as a pull while 16 characters are held. The fill level must stay at 16 and overrun must stay clear. The pulled character must be the oldest, and the new one must come out last when the queue is drained.
- **Flush and arrival.** A character is driven together with a flush. The fill level must read zero afterwards, with overrun clear.
- **Framing error and clear.** A character carrying a framing error is driven together with a command that clears the framing flag. The flag must read set.
- **Set and clear of one flag.** Both commands for the same flag are issued in one command word. The flag must read set.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int NFLAG      = 5;
  localparam int FL_RDY     = 0;
  localparam int FL_OVR     = 1;
  localparam int FL_BRK     = 2;
  localparam int FL_FRM     = 3;
  localparam int FL_PAR     = 4;
  localparam int CMD_SET_LSB = NFLAG;
  localparam int CMD_PULL   = 2 * NFLAG;
  localparam int CMD_FLUSH  = 2 * NFLAG + 1;
  localparam int CMD_W      = 2 * NFLAG + 2;
  localparam int ST_CNT_LSB = 6;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int CHAR_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              flush,
  output logic              wr_acc,
  output logic              wr_drop,
  output logic [CHAR_W-1:0] rd_data,
  output logic [CW-1:0]     fill
);
  logic [CHAR_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              rd_acc, full;

  assign full    = (fill == CW'(DEPTH));
  assign rd_acc  = rd_req && !flush && (fill != '0);
  assign wr_acc  = wr_req && !flush && (!full || rd_acc);
  assign wr_drop = wr_req && !flush && !wr_acc;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_acc) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_acc) wr_ptr <= nxt(wr_ptr);
      if (rd_acc) rd_ptr <= nxt(rd_ptr);
      case ({wr_acc, rd_acc})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (rst)
    wr_drop |-> (fill == CW'(DEPTH)));
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill == '0));
  p_pull_empty_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && fill == '0 && !wr_req) |=> $stable(rd_data));
endmodule

// File: rtl/rxq_ready_timer.sv
module rxq_ready_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             empty,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  logic             active;
  logic [DLY_W-1:0] rem;

  assign fire = active && (rem == '0) && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      rem    <= '0;
    end else if (arm) begin
      active <= 1'b1;
      rem    <= dly;
    end else if (empty || fire) begin
      active <= 1'b0;
    end else if (active && tick && rem != '0) begin
      rem <= rem - DLY_W'(1);
    end
  end

  p_arm_loads_r7: assert property (@(posedge clk) disable iff (rst)
    arm |=> (active && rem == $past(dly)));
  p_fire_single_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/rxq_flag_bank.sv
module rxq_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_ev,
  input  logic [N-1:0] set_cmd,
  input  logic [N-1:0] clr_cmd,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= hw_ev[i] | set_cmd[i] | (flags[i] & ~clr_cmd[i]);
    end

    p_hw_wins_r6: assert property (@(posedge clk) disable iff (rst)
      hw_ev[i] |=> flags[i]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      set_cmd[i] |=> flags[i]);
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_cmd[i] && !set_cmd[i] && !hw_ev[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CHAR_W = 8,
  parameter int DLY_W  = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int ST_W  = ST_CNT_LSB + CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_brk,
  input  logic              rx_ferr,
  input  logic              rx_perr,
  input  logic              bit_tick,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [DLY_W-1:0]  cfg_ready_delay,
  input  logic [NFLAG-1:0]  cfg_irq_en,
  output logic [CHAR_W-1:0] rd_char,
  output logic [ST_W-1:0]   status_word,
  output logic              irq
);
  logic             wr_acc, wr_drop, flush, pull, tmr_fire;
  logic [CW-1:0]    fill;
  logic [NFLAG-1:0] hw_ev, set_cmd, clr_cmd, flags;

  assign flush   = cmd_we && cmd_word[CMD_FLUSH];
  assign pull    = cmd_we && cmd_word[CMD_PULL];
  assign clr_cmd = cmd_we ? cmd_word[NFLAG-1:0] : '0;
  assign set_cmd = cmd_we ? cmd_word[CMD_SET_LSB +: NFLAG] : '0;

  rxq_store #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_req(rx_valid), .wr_data(rx_char),
    .rd_req(pull), .flush(flush),
    .wr_acc(wr_acc), .wr_drop(wr_drop),
    .rd_data(rd_char), .fill(fill)
  );

  rxq_ready_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst),
    .arm(wr_acc && fill == '0),
    .empty(fill == '0),
    .tick(bit_tick),
    .dly(cfg_ready_delay),
    .fire(tmr_fire)
  );

  always_comb begin
    hw_ev         = '0;
    hw_ev[FL_RDY] = tmr_fire || (fill == CW'(DEPTH));
    hw_ev[FL_OVR] = wr_drop;
    hw_ev[FL_BRK] = rx_valid && rx_brk;
    hw_ev[FL_FRM] = rx_valid && rx_ferr;
    hw_ev[FL_PAR] = rx_valid && rx_perr;
  end

  rxq_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst),
    .hw_ev(hw_ev), .set_cmd(set_cmd), .clr_cmd(clr_cmd),
    .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & cfg_irq_en);
  end

  assign status_word = {fill, flags[FL_PAR], flags[FL_FRM], flags[FL_BRK],
                        flags[FL_OVR], 1'b0, flags[FL_RDY]};

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(flags & cfg_irq_en))));
  p_full_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH)) |=> flags[FL_RDY]);
  p_drop_overrun_r3: assert property (@(posedge clk) disable iff (rst)
    wr_drop |=> flags[FL_OVR]);
  p_spare_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !status_word[1]);
endmodule

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_brk = 1'b0, rx_ferr = 1'b0, rx_perr = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        bit_tick = 1'b0, cmd_we = 1'b0;
  logic [11:0] cmd_word = '0;
  logic [7:0]  cfg_ready_delay = 8'd200;
  logic [4:0]  cfg_irq_en = '0;
  logic [7:0]  rd_char;
  logic [10:0] status_word;
  logic        irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_buffer u_uart_rx_buffer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .bit_tick(bit_tick), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .cfg_ready_delay(cfg_ready_delay), .cfg_irq_en(cfg_irq_en),
    .rd_char(rd_char), .status_word(status_word), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one clock of stimulus, returns at the falling edge after it was consumed
  task automatic step(bit v, logic [7:0] ch, bit b, bit f, bit p,
                      bit we, logic [11:0] cmd, bit tk);
    rx_valid = v; rx_char = ch; rx_brk = b; rx_ferr = f; rx_perr = p;
    cmd_we = we; cmd_word = cmd; bit_tick = tk;
    @(negedge clk);
    rx_valid = 0; rx_brk = 0; rx_ferr = 0; rx_perr = 0;
    cmd_we = 0; cmd_word = '0; bit_tick = 0;
  endtask

  task automatic idle();        step(0, 8'h0, 0, 0, 0, 0, 12'h0, 0); endtask
  task automatic send(logic [7:0] c); step(1, c, 0, 0, 0, 0, 12'h0, 0); endtask
  task automatic cmd(logic [11:0] w); step(0, 8'h0, 0, 0, 0, 1, w, 0); endtask
  task automatic wipe();        cmd(12'h81F); endtask

  task automatic t_reset();
    check("R1 status after reset", status_word, 0);
    check("R1 irq after reset", irq, 0);
    check("R11 spare bit zero", status_word[1], 0);
  endtask

  task automatic t_errors();
    step(1, 8'h41, 1, 0, 0, 0, 12'h0, 0);
    step(1, 8'h42, 0, 1, 0, 0, 12'h0, 0);
    step(1, 8'h43, 0, 0, 1, 0, 12'h0, 0);
    check("R4 brk/fe/pe flags", status_word[5:2], 4'b1110);
    check("R2 fill after three", status_word[10:6], 3);
    wipe();
    check("R9 flush and clear all", status_word, 0);
  endtask

  task automatic t_set_clear();
    cmd(12'h040);
    check("R5 set overrun", status_word[2], 1);
    cmd(12'h042);
    check("R5 set with clear keeps set", status_word[2], 1);
    cmd(12'h002);
    check("R5 clear overrun", status_word[2], 0);
    cmd(12'h3E0);
    check("R5 set all five", {status_word[5:2], status_word[0]}, 5'h1F);
    cmd(12'h01F);
    check("R5 clear all five", status_word, 0);
  endtask

  task automatic t_hw_vs_clear();
    step(1, 8'h55, 0, 1, 0, 1, 12'h008, 0);
    check("R6 framing event beats clear", status_word[4], 1);
    wipe();
  endtask

  task automatic t_delay();
    cfg_ready_delay = 8'd3;
    send(8'h01);
    check("R7 ready not yet", status_word[0], 0);
    step(0, 8'h0, 0, 0, 0, 0, 12'h0, 1);
    step(0, 8'h0, 0, 0, 0, 0, 12'h0, 1);
    idle(); idle();
    check("R7 ready held after two ticks", status_word[0], 0);
    step(0, 8'h0, 0, 0, 0, 0, 12'h0, 1);
    check("R7 ready still low on third tick", status_word[0], 0);
    idle();
    check("R7 ready after delay", status_word[0], 1);
    wipe();
    cfg_ready_delay = 8'd0;
    send(8'h02);
    check("R7 zero delay not same clock", status_word[0], 0);
    idle();
    check("R7 zero delay ready", status_word[0], 1);
    wipe();
    cfg_ready_delay = 8'd200;
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) send(8'h10 + 8'(i));
    check("R2 fill 16", status_word[10:6], 16);
    check("R8 ready not before full seen", status_word[0], 0);
    idle();
    check("R8 ready on full", status_word[0], 1);
    send(8'h99);
    check("R3 drop keeps fill", status_word[10:6], 16);
    check("R3 overrun set", status_word[2], 1);
    cmd(12'h002);
    step(1, 8'hAA, 0, 0, 0, 1, 12'h400, 0);
    check("R3 pull with arrival keeps fill", status_word[10:6], 16);
    check("R3 no overrun with pull", status_word[2], 0);
    check("R2 oldest pulled", rd_char, 8'h10);
    for (int i = 1; i < 16; i++) begin
      cmd(12'h400);
      check("R2 order", rd_char, 8'h10 + 8'(i));
    end
    cmd(12'h400);
    check("R3 accepted char last", rd_char, 8'hAA);
    check("R2 drained", status_word[10:6], 0);
    cmd(12'h400);
    check("R9 pull on empty keeps data", rd_char, 8'hAA);
    check("R9 pull on empty keeps fill", status_word[10:6], 0);
    wipe();
  endtask

  task automatic t_flush_arrival();
    send(8'h31);
    step(1, 8'h32, 0, 0, 0, 1, 12'h800, 0);
    check("R9 flush with arrival empties", status_word[10:6], 0);
    check("R9 no overrun on flush", status_word[2], 0);
  endtask

  task automatic t_irq();
    cfg_irq_en = 5'b00000;
    cmd(12'h040);
    idle();
    check("R10 masked flag no irq", irq, 0);
    cfg_irq_en = 5'b00010;
    idle();
    check("R10 enabled flag irq", irq, 1);
    cmd(12'h002);
    check("R10 irq lags clear", irq, 1);
    idle();
    check("R10 irq drops", irq, 0);
    cfg_irq_en = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_errors();
    t_set_clear();
    t_hw_vs_clear();
    t_delay();
    t_full();
    t_flush_arrival();
    t_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule